// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one eight-pin general-purpose I/O port. It sits behind two simple register write ports. A host port can write and read. A sequencer port can only write. Both ports share one address map. An output data register can be written whole, or changed bit by bit through three alias addresses. Writing a 1 in a data bit sets, clears or inverts the matching output bit, and every bit written as 0 stays as it was. Per-pin registers enable the output driver, the input path and the pull-up.

A two-bit field per pin selects where that pin's drive value comes from: the port data register, a sync register that the sequencer writes, or one of two interrupt-pending levels. The interrupt levels come from an interrupt controller outside the block. Pin inputs pass through a two-flop synchronizer. They can be read back only on pins whose input path is enabled.

Top module: `gpio_port`

Address map (4-bit address): 0 data, 1 set alias, 2 clear alias, 3 toggle alias, 4 drive enable, 5 input enable, 6 pull-up enable, 7 source select (16 bits), 8 pin levels (read only), 9 sync register. Reads of the aliases return the data register. Unmapped addresses read 0.

## Requirements
- R1: After reset every register reads 0, and `pad_out`, `pad_oe` and `pad_pu` are all 0.
- R2: A write to address 0 loads `wdata[7:0]` into the data register. The new value reads back from the next cycle on.
- R3: A write to address 1 sets each data bit whose write bit is 1. All other data bits are unchanged.
- R4: A write to address 2 clears each data bit whose write bit is 1. All other data bits are unchanged.
- R5: A write to address 3 inverts each data bit whose write bit is 1. All other data bits are unchanged.
- R6: Source select holds one field per pin, pin i at bits [2i+1:2i]: 0 = data register, 1 = sync register, 2 = interrupt 0 pending, 3 = interrupt 1 pending. `pad_out[i]` is the selected source when drive enable bit i is 1, and 0 when it is 0. `pad_oe` equals the drive enable register.
- R7: Address 8 reads the synchronized pin levels ANDed with the input enable register. A change on `pad_in` is visible after the second rising clock edge, and not after the first.
- R8: The pull-up register has no bit for pin 2. That bit reads 0 and drives 0 on `pad_pu[2]` whatever is written. The other bits read back as written and drive `pad_pu`.
- R9: Address 9 is written by either port. With a pin's drive enable set and its select set to 1, the pin drives the sync bit.
- R10: Data register operations that arrive in the same cycle, from the two ports, are resolved per bit. The priority is direct write > clear > set > toggle. If both ports do a direct write, the host port's data is used.
- R11: Writes to unmapped addresses or to address 8 change no register. Write bits above bit 7 are dropped for the 8-bit registers. When both ports write the same configuration register in one cycle, the host port wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host address, used for both write and read |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from `host_addr` |
| seq_we | input | 1 | Sequencer write strobe |
| seq_addr | input | 4 | Sequencer write address |
| seq_wdata | input | 16 | Sequencer write data |
| irq_pending | input | 2 | Pending levels of interrupts 0 and 1 |
| pad_in | input | 8 | Pin input levels, asynchronous |
| pad_out | output | 8 | Pin drive values |
| pad_oe | output | 8 | Pin driver enables |
| pad_pu | output | 8 | Pin pull-up enables |

## Verification
The two ports can both change the data register in the same cycle. For example, the host does a direct write while the sequencer clears, or one port sets a bit while the other toggles it. The bench drives all 25 pairings of none, direct, clear, set and toggle from the two ports, with both strobes raised in the same cycle. It starts from a data value, and uses write masks chosen so that every bit lands in a different overlap of the two masks. The value read back is compared with a per-bit model of the priority order, computed in the bench.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_DATA = 4'd0;
    localparam logic [ADDR_W-1:0] A_SET  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_TGL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DRV  = 4'd4;
    localparam logic [ADDR_W-1:0] A_SNS  = 4'd5;
    localparam logic [ADDR_W-1:0] A_PUL  = 4'd6;
    localparam logic [ADDR_W-1:0] A_FSEL = 4'd7;
    localparam logic [ADDR_W-1:0] A_PIN  = 4'd8;
    localparam logic [ADDR_W-1:0] A_SYNC = 4'd9;

    typedef enum logic [1:0] {
        SRC_DATA = 2'd0,
        SRC_SYNC = 2'd1,
        SRC_IRQ0 = 2'd2,
        SRC_IRQ1 = 2'd3
    } pin_src_e;
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
    import gpio_pkg::*;
#(
    parameter int W = 8,
    parameter logic [ADDR_W-1:0] ADDR = 4'd4,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [W-1:0]      h_wdata,
    input  logic              s_we,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [W-1:0]      s_wdata,
    output logic [W-1:0]      q
);
    logic h_hit, s_hit;

    assign h_hit = h_we && (h_addr == ADDR);
    assign s_hit = s_we && (s_addr == ADDR);

    // host port wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (h_hit)
            q <= h_wdata & KEEP;
        else if (s_hit)
            q <= s_wdata & KEEP;
    end
endmodule

// File: rtl/gpio_data_arb.sv
module gpio_data_arb
    import gpio_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]      q,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [N-1:0]      h_wdata,
    input  logic              s_we,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [N-1:0]      s_wdata,
    output logic [N-1:0]      nxt
);
    localparam int NP = 2;

    logic              we_a   [NP];
    logic [ADDR_W-1:0] addr_a [NP];
    logic [N-1:0]      wd_a   [NP];
    logic [NP-1:0]     dir_hit;
    logic [N-1:0]      clr_p [NP];
    logic [N-1:0]      set_p [NP];
    logic [N-1:0]      tgl_p [NP];

    assign we_a[0]   = h_we;
    assign addr_a[0] = h_addr;
    assign wd_a[0]   = h_wdata;
    assign we_a[1]   = s_we;
    assign addr_a[1] = s_addr;
    assign wd_a[1]   = s_wdata;

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign dir_hit[p] = we_a[p] && (addr_a[p] == A_DATA);
        assign clr_p[p] = (we_a[p] && addr_a[p] == A_CLR) ? wd_a[p] : '0;
        assign set_p[p] = (we_a[p] && addr_a[p] == A_SET) ? wd_a[p] : '0;
        assign tgl_p[p] = (we_a[p] && addr_a[p] == A_TGL) ? wd_a[p] : '0;
    end

    logic [N-1:0] clr_m, set_m, tgl_m, dir_val;

    assign clr_m   = clr_p[0] | clr_p[1];
    assign set_m   = set_p[0] | set_p[1];
    assign tgl_m   = tgl_p[0] | tgl_p[1];
    assign dir_val = dir_hit[0] ? wd_a[0] : wd_a[1];

    // lowest priority applied first, each later stage overrides
    always_comb begin
        if (|dir_hit)
            nxt = dir_val;
        else
            nxt = ((q ^ tgl_m) | set_m) & ~clr_m;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] fsel,
    input  logic [N-1:0]   data,
    input  logic [N-1:0]   sync,
    input  logic [1:0]     irq,
    input  logic [N-1:0]   oe,
    output logic [N-1:0]   drive
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_src_e src;
        logic     val;

        assign src = pin_src_e'(fsel[2*i +: 2]);

        always_comb begin
            unique case (src)
                SRC_DATA: val = data[i];
                SRC_SYNC: val = sync[i];
                SRC_IRQ0: val = irq[0];
                SRC_IRQ1: val = irq[1];
                default:  val = 1'b0;
            endcase
        end

        assign drive[i] = oe[i] & val;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [N_PINS-1:0] NO_PULL = 8'h04
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [2*N_PINS-1:0] host_wdata,
    output logic [2*N_PINS-1:0] host_rdata,
    input  logic                seq_we,
    input  logic [ADDR_W-1:0]   seq_addr,
    input  logic [2*N_PINS-1:0] seq_wdata,
    input  logic [1:0]          irq_pending,
    input  logic [N_PINS-1:0]   pad_in,
    output logic [N_PINS-1:0]   pad_out,
    output logic [N_PINS-1:0]   pad_oe,
    output logic [N_PINS-1:0]   pad_pu
);
    localparam int N  = N_PINS;
    localparam int DW = 2 * N_PINS;
    localparam logic [N-1:0] PULL_KEEP = ~NO_PULL;

    logic [N-1:0]  out_q, out_nxt;
    logic [N-1:0]  drv_q, sns_q, pul_q, sync_q, pin_s;
    logic [DW-1:0] fsel_q;

    gpio_data_arb #(.N(N)) u_arb (
        .q       (out_q),
        .h_we    (host_we),
        .h_addr  (host_addr),
        .h_wdata (host_wdata[N-1:0]),
        .s_we    (seq_we),
        .s_addr  (seq_addr),
        .s_wdata (seq_wdata[N-1:0]),
        .nxt     (out_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_nxt;
    end

    gpio_cfg_reg #(.W(N), .ADDR(A_DRV), .KEEP('1)) u_drv (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata[N-1:0]),
        .s_we(seq_we), .s_addr(seq_addr), .s_wdata(seq_wdata[N-1:0]),
        .q(drv_q)
    );

    gpio_cfg_reg #(.W(N), .ADDR(A_SNS), .KEEP('1)) u_sns (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata[N-1:0]),
        .s_we(seq_we), .s_addr(seq_addr), .s_wdata(seq_wdata[N-1:0]),
        .q(sns_q)
    );

    gpio_cfg_reg #(.W(N), .ADDR(A_PUL), .KEEP(PULL_KEEP)) u_pul (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata[N-1:0]),
        .s_we(seq_we), .s_addr(seq_addr), .s_wdata(seq_wdata[N-1:0]),
        .q(pul_q)
    );

    gpio_cfg_reg #(.W(N), .ADDR(A_SYNC), .KEEP('1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata[N-1:0]),
        .s_we(seq_we), .s_addr(seq_addr), .s_wdata(seq_wdata[N-1:0]),
        .q(sync_q)
    );

    gpio_cfg_reg #(.W(DW), .ADDR(A_FSEL), .KEEP('1)) u_fsel (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata),
        .s_we(seq_we), .s_addr(seq_addr), .s_wdata(seq_wdata),
        .q(fsel_q)
    );

    gpio_in_sync #(.N(N), .STAGES(SYNC_STAGES)) u_insync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
    );

    gpio_pin_mux #(.N(N)) u_mux (
        .fsel  (fsel_q),
        .data  (out_q),
        .sync  (sync_q),
        .irq   (irq_pending),
        .oe    (drv_q),
        .drive (pad_out)
    );

    assign pad_oe = drv_q;
    assign pad_pu = pul_q;

    localparam logic [DW-N-1:0] ZPAD = '0;

    always_comb begin
        unique case (host_addr)
            A_DATA, A_SET, A_CLR, A_TGL: host_rdata = {ZPAD, out_q};
            A_DRV:  host_rdata = {ZPAD, drv_q};
            A_SNS:  host_rdata = {ZPAD, sns_q};
            A_PUL:  host_rdata = {ZPAD, pul_q};
            A_FSEL: host_rdata = fsel_q;
            A_PIN:  host_rdata = {ZPAD, pin_s & sns_q};
            A_SYNC: host_rdata = {ZPAD, sync_q};
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int N = 8,
    parameter logic [N-1:0] NO_PULL = 8'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [N-1:0]      host_wdata,
    input logic              seq_we,
    input logic [N-1:0]      pad_out,
    input logic [N-1:0]      pad_oe,
    input logic [N-1:0]      pad_pu,
    input logic [N-1:0]      out_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_pu == '0 && out_q == '0));

    // R2
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_DATA) |=> out_q == $past(host_wdata));

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_SET && !seq_we)
        |=> out_q == ($past(out_q) | $past(host_wdata)));

    // R4
    clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_CLR && !seq_we)
        |=> out_q == ($past(out_q) & ~$past(host_wdata)));

    // R5
    toggle_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_TGL && !seq_we)
        |=> out_q == ($past(out_q) ^ $past(host_wdata)));

    // R6
    undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R8
    pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_PUL)
        |=> pad_pu == ($past(host_wdata) & ~NO_PULL));
endmodule

bind gpio_port gpio_port_chk #(.N(N_PINS), .NO_PULL(NO_PULL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata[N_PINS-1:0]),
    .seq_we     (seq_we),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .out_q      (out_q)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        seq_we = 1'b0;
    logic [3:0]  seq_addr = '0;
    logic [15:0] seq_wdata = '0;
    logic [1:0]  irq_pending = '0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_pu;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_we(seq_we), .seq_addr(seq_addr), .seq_wdata(seq_wdata),
        .irq_pending(irq_pending), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr2(input bit hw, input logic [3:0] ha, input logic [15:0] hd,
                       input bit sw, input logic [3:0] sa, input logic [15:0] sd);
        @(negedge clk);
        host_we = hw; host_addr = ha; host_wdata = hd;
        seq_we = sw; seq_addr = sa; seq_wdata = sd;
        @(negedge clk);
        host_we = 1'b0; seq_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr2(1'b1, a, d, 1'b0, 4'd0, 16'd0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [3:0] op_addr(input int op);
        case (op)
            1: return 4'd0;
            2: return 4'd2;
            3: return 4'd1;
            default: return 4'd3;
        endcase
    endfunction

    // ops: 0 none, 1 direct, 2 clear, 3 set, 4 toggle
    function automatic logic [7:0] prio(input logic [7:0] q, input int hop, input logic [7:0] hd,
                                        input int sop, input logic [7:0] sd);
        logic [7:0] r;
        if (hop == 1) return hd;
        if (sop == 1) return sd;
        for (int b = 0; b < 8; b++) begin
            bit c, s, t;
            c = (hop == 2 && hd[b]) || (sop == 2 && sd[b]);
            s = (hop == 3 && hd[b]) || (sop == 3 && sd[b]);
            t = (hop == 4 && hd[b]) || (sop == 4 && sd[b]);
            r[b] = c ? 1'b0 : s ? 1'b1 : t ? ~q[b] : q[b];
        end
        return r;
    endfunction

    function automatic logic [7:0] pins(input logic [15:0] fs, input logic [7:0] d,
                                        input logic [7:0] sy, input logic [1:0] ir,
                                        input logic [7:0] oe);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            int sel;
            sel = int'(fs[2*i +: 2]);
            r[i] = oe[i] & ((sel == 0) ? d[i] : (sel == 1) ? sy[i] : ir[sel-2]);
        end
        return r;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pad_oe", {8'h0, pad_oe}, 16'h0);
        chk("R1 pad_pu", {8'h0, pad_pu}, 16'h0);
        chk("R1 pad_out", {8'h0, pad_out}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 reg read", v, 16'h0);
        end

        // R2: direct writes
        for (int d = 0; d < 256; d += 37) begin
            wr(4'd0, 16'hAB00 | 16'(d));
            rd(4'd0, v);
            chk("R2 direct", v, 16'(d));
        end

        // R3 R4 R5: alias sweeps
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                logic [7:0] st, mk;
                st = 8'(s * 17) ^ 8'h5A;
                mk = {4'(m), ~4'(m)} ^ 8'(s);
                wr(4'd0, {8'h0, st});
                wr(4'd1, {8'hFF, mk});
                rd(4'd1, v);
                chk("R3 set", v, {8'h0, st | mk});
                wr(4'd0, {8'h0, st});
                wr(4'd2, {8'hFF, mk});
                rd(4'd2, v);
                chk("R4 clear", v, {8'h0, st & ~mk});
                wr(4'd0, {8'h0, st});
                wr(4'd3, {8'hFF, mk});
                rd(4'd3, v);
                chk("R5 toggle", v, {8'h0, st ^ mk});
            end
        end

        // R10: same-cycle pairs from both ports
        for (int h = 0; h < 5; h++) begin
            for (int s = 0; s < 5; s++) begin
                logic [7:0] q0, hd, sd;
                q0 = 8'hA5; hd = 8'h3C; sd = 8'h0F;
                wr(4'd0, {8'h0, q0});
                wr2(h != 0, op_addr(h), {8'h0, hd}, s != 0, op_addr(s), {8'h0, sd});
                rd(4'd0, v);
                chk("R10 priority", v, {8'h0, prio(q0, h, hd, s, sd)});
            end
        end

        // R6 R9: pin source select
        wr(4'd0, 16'h005A);
        wr2(1'b0, 4'd0, 16'h0, 1'b1, 4'd9, 16'h00C3);
        rd(4'd9, v);
        chk("R9 sync readback", v, 16'h00C3);
        irq_pending = 2'b01;
        wr(4'd4, 16'h00FF);
        chk("R6 pad_oe", {8'h0, pad_oe}, 16'h00FF);
        for (int p = 0; p < 6; p++) begin
            logic [15:0] fs;
            case (p)
                0: fs = 16'h0000;
                1: fs = 16'h5555;
                2: fs = 16'hAAAA;
                3: fs = 16'hFFFF;
                4: fs = 16'hE4E4;
                default: fs = 16'h1B1B;
            endcase
            wr(4'd7, fs);
            rd(4'd7, v);
            chk("R6 fsel readback", v, fs);
            chk("R6 R9 pad_out", {8'h0, pad_out}, {8'h0, pins(fs, 8'h5A, 8'hC3, 2'b01, 8'hFF)});
        end
        irq_pending = 2'b10;
        #1;
        chk("R6 irq swap", {8'h0, pad_out}, {8'h0, pins(16'h1B1B, 8'h5A, 8'hC3, 2'b10, 8'hFF)});
        wr(4'd4, 16'h000F);
        wr(4'd7, 16'h0000);
        chk("R6 oe gated", {8'h0, pad_out}, 16'h000A);
        wr(4'd7, 16'h5555);
        chk("R9 sync gated", {8'h0, pad_out}, 16'h0003);

        // R7: input path with latency
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ie, pv, pold;
            ie = 8'(8'hF0 >> k) | 8'(k * 3);
            pv = 8'(8'h96 + k * 29);
            wr(4'd5, {8'h0, ie});
            @(negedge clk);
            pold = pad_in;
            pad_in = pv;
            @(negedge clk);
            rd(4'd8, v);
            chk("R7 one edge old", v, {8'h0, pold & ie});
            @(negedge clk);
            rd(4'd8, v);
            chk("R7 two edges", v, {8'h0, pv & ie});
        end

        // R8: pull-up without pin 2
        wr(4'd6, 16'hFFFF);
        chk("R8 pad_pu", {8'h0, pad_pu}, 16'h00FB);
        rd(4'd6, v);
        chk("R8 read", v, 16'h00FB);
        wr2(1'b0, 4'd0, 16'h0, 1'b1, 4'd6, 16'h0004);
        chk("R8 seq pin2", {8'h0, pad_pu}, 16'h0000);

        // R11: ignored writes and collisions
        wr(4'd0, 16'h0066);
        wr(4'd4, 16'hFF00);
        rd(4'd4, v);
        chk("R11 upper bits", v, 16'h0000);
        wr(4'd12, 16'hFFFF);
        wr(4'd15, 16'hFFFF);
        wr(4'd8, 16'hFFFF);
        rd(4'd0, v);
        chk("R11 data kept", v, 16'h0066);
        rd(4'd4, v);
        chk("R11 drive kept", v, 16'h0000);
        rd(4'd6, v);
        chk("R11 pull kept", v, 16'h0000);
        rd(4'd9, v);
        chk("R11 sync kept", v, 16'h00C3);
        wr2(1'b1, 4'd5, 16'h0011, 1'b1, 4'd5, 16'h0022);
        rd(4'd5, v);
        chk("R11 host wins", v, 16'h0011);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule